// File: doc/BRIEF.md
# Per-Channel Trigger Acceptance Sequencer

This block is the local, self-timed trigger logic of a single detector channel. A discriminator hit arms the channel: after a programmable delay it opens a fast-trigger acceptance window, and on the closing cycle of that window it looks at the broadcast fast trigger to decide whether the channel takes part in the event. A channel that joins counts out the rest of its shaping time, then runs its conversion phase and, during conversion, opens a validation acceptance window whose closing cycle decides between requesting readout and dropping the event.

There is no clear input. Every return to the armed state comes from the channel's own timers: after any outcome, whether the fast trigger was missed, the event was rejected, or readout was requested, the channel holds for a programmable recovery time and then re-arms. A broadcast event reject stops the channel before conversion if it arrives in time. Otherwise it lets the running conversion finish and only withholds readout. All timing parameters are counted in clock cycles and are held stable by the user while the channel is idle.

Top module: `chanTrigSeq`

## Requirements
- R1: After reset the channel is idle, and busy, fastWinOpen, valWinOpen, convertStart and readoutReq are all low.
- R2: A cfdHit sampled high while idle makes busy rise in the next cycle. fastWinOpen is then high for cfgFastWin cycles, starting after cfgDelay cycles. With cfgDelay of 0 it is high from the first busy cycle.
- R3: fastTrig is sampled on the last cycle of the fast window. When it is low, the channel never asserts convertStart or readoutReq and goes straight into recovery in the next cycle.
- R4: When the channel joins, cfgShape shaping cycles follow the window. cfgConvert conversion cycles follow the shaping cycles, and convertStart is high for exactly the first conversion cycle.
- R5: The validation window opens at one of two points. With cfgValFromHit = 0 it opens cfgValDelay cycles after the first conversion cycle. With cfgValFromHit = 1 it opens in the first conversion cycle whose count since the hit (first busy cycle = 1) reaches cfgValDelay, and never before conversion. It stays open for cfgValWidth cycles.
- R6: validate is sampled on the last cycle of the validation window. When it is high and there has been no reject, readoutReq is high for every recovery cycle. When it is low, readoutReq stays low.
- R7: If the validation window outlasts conversion, the channel stays busy until the window's last cycle and starts recovery in the next cycle.
- R8: An eventReject sampled during shaping cancels the conversion: convertStart never rises, and recovery starts in the next cycle.
- R9: An eventReject sampled during conversion, before the validation decision, lets the conversion run its full length, closes the validation window and withholds readout.
- R10: An eventReject sampled after the validation decision is ignored. A reject in the same cycle as the decision wins over validation.
- R11: Recovery lasts cfgRecover cycles, after which busy falls. A cfdHit while busy has no effect, and a hit on the first idle cycle starts a new event.
- R12: While idle, fastTrig, validate and eventReject have no effect on any output.
- R13: Window, shaping, conversion and recovery lengths of 0 are treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock; one cycle is one timing step |
| rstN | input | 1 | Asynchronous active-low reset |
| cfdHit | input | 1 | Discriminator hit |
| fastTrig | input | 1 | Broadcast fast trigger level |
| validate | input | 1 | Broadcast validation level |
| eventReject | input | 1 | Broadcast event reject |
| cfgDelay | input | CNT_W | Cycles from hit to fast window open |
| cfgFastWin | input | CNT_W | Fast window length |
| cfgShape | input | CNT_W | Shaping cycles after joining |
| cfgConvert | input | CNT_W | Conversion length |
| cfgValDelay | input | CNT_W | Validation window offset |
| cfgValWidth | input | CNT_W | Validation window length |
| cfgValFromHit | input | 1 | 1: offset counted from the hit; 0: from conversion start |
| cfgRecover | input | CNT_W | Recovery length |
| busy | output | 1 | Channel engaged and ignoring hits |
| fastWinOpen | output | 1 | Fast-trigger acceptance window open |
| valWinOpen | output | 1 | Validation acceptance window open |
| convertStart | output | 1 | One-cycle conversion start strobe |
| readoutReq | output | 1 | Readout requested for the current event |

## Verification
Events are driven with the fast trigger held present or absent across the window and validation held high or low, so that joining, abandoning, readout and no-readout outcomes are all produced. A reject pulse is placed in the delay, window, shaping, conversion, waiting and recovery phases, and exactly on the decision cycle. This separates the cancel-before-conversion, finish-without-readout and ignore-after-decision behaviours. Both validation timing modes are used, including offsets that would open the window before conversion and windows that outlast conversion, together with repeated hits during busy periods and back-to-back events.

// File: rtl/trigSeqPkg.sv
package trigSeqPkg;

  typedef enum logic [2:0] {
    SIdle,
    SDelay,
    SFastWin,
    SShape,
    SConvert,
    SAwaitVal,
    SRecover
  } seqState_e;

  // which configured length the phase timer loads
  typedef enum logic [2:0] {
    LenDelay,
    LenFastWin,
    LenShape,
    LenConvert,
    LenRecover
  } lenSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    loadPhase;
    lenSel_e lenSel;
    logic    startHit;
    logic    startConv;
    logic    valTick;
  } tmrCmd_t;

endpackage

// File: rtl/trigSeqTimers.sv
module trigSeqTimers
  import trigSeqPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmd_t          cmd,
  input  logic [CNT_W-1:0] cfgDelay,
  input  logic [CNT_W-1:0] cfgFastWin,
  input  logic [CNT_W-1:0] cfgShape,
  input  logic [CNT_W-1:0] cfgConvert,
  input  logic [CNT_W-1:0] cfgValDelay,
  input  logic [CNT_W-1:0] cfgValWidth,
  input  logic             cfgValFromHit,
  input  logic [CNT_W-1:0] cfgRecover,
  output logic             phaseDone,
  output logic             delayZero,
  output logic             convFirst,
  output logic             valRefReached,
  output logic             valLast
);

  localparam int EL_W = CNT_W + 1;
  localparam logic [EL_W-1:0] EL_MAX = '1;
  localparam int NUM_EL = 2;

  function automatic logic [CNT_W-1:0] lenToCnt(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] selLen;
  logic [CNT_W-1:0] valCnt;
  logic [EL_W-1:0]  elapsedVec [NUM_EL];
  logic [NUM_EL-1:0] startVec;
  logic [EL_W-1:0]  valRef;

  always_comb begin
    unique case (cmd.lenSel)
      LenDelay:   selLen = cfgDelay;
      LenFastWin: selLen = cfgFastWin;
      LenShape:   selLen = cfgShape;
      LenConvert: selLen = cfgConvert;
      default:    selLen = cfgRecover;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (cmd.loadPhase) begin
      phaseCnt <= lenToCnt(selLen);
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
    end
  end

  // elapsed counters: [0] cycles since the hit, [1] cycles since conversion start
  assign startVec = {cmd.startConv, cmd.startHit};

  for (genvar i = 0; i < NUM_EL; i++) begin : gElapsed
    localparam logic [EL_W-1:0] START_VAL = (i == 0) ? EL_W'(1) : EL_W'(0);
    logic [EL_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (startVec[i]) begin
        cnt <= START_VAL;
      end else if (cnt != EL_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
    assign elapsedVec[i] = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valCnt <= '0;
    end else if (cmd.startHit) begin
      valCnt <= '0;
    end else if (cmd.valTick) begin
      valCnt <= valCnt + 1'b1;
    end
  end

  assign valRef        = cfgValFromHit ? elapsedVec[0] : elapsedVec[1];
  assign valRefReached = valRef >= {1'b0, cfgValDelay};
  assign valLast       = valCnt == lenToCnt(cfgValWidth);
  assign phaseDone     = phaseCnt == '0;
  assign delayZero     = cfgDelay == '0;
  assign convFirst     = elapsedVec[1] == '0;

endmodule

// File: rtl/trigSeqCtrl.sv
module trigSeqCtrl
  import trigSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfdHit,
  input  logic    fastTrig,
  input  logic    validate,
  input  logic    eventReject,
  input  logic    phaseDone,
  input  logic    delayZero,
  input  logic    convFirst,
  input  logic    valRefReached,
  input  logic    valLast,
  output tmrCmd_t cmd,
  output logic    busy,
  output logic    fastWinOpen,
  output logic    valWinOpen,
  output logic    convertStart,
  output logic    readoutReq
);

  seqState_e state, stateNext;
  logic valDecided, valDecidedNext;
  logic valOk, valOkNext;
  logic rejected, rejectedNext;
  logic readFlag, readFlagNext;
  logic inConvPhase, rejNow, decideNow, passNow;

  assign inConvPhase = (state == SConvert) || (state == SAwaitVal);
  assign valWinOpen  = inConvPhase && !valDecided && !rejected && valRefReached;
  assign rejNow      = eventReject && !valDecided && !rejected &&
                       ((state == SShape) || inConvPhase);
  // a reject in the decision cycle takes precedence
  assign decideNow   = valWinOpen && valLast && !rejNow;
  assign passNow     = decideNow && validate;

  always_comb begin
    stateNext      = state;
    valDecidedNext = valDecided;
    valOkNext      = valOk;
    rejectedNext   = rejected || rejNow;
    readFlagNext   = readFlag;
    cmd            = '0;
    cmd.lenSel     = LenRecover;
    cmd.valTick    = valWinOpen;

    if (decideNow) begin
      valDecidedNext = 1'b1;
      valOkNext      = validate;
    end

    unique case (state)
      SIdle: begin
        if (cfdHit) begin
          cmd.startHit   = 1'b1;
          cmd.loadPhase  = 1'b1;
          valDecidedNext = 1'b0;
          valOkNext      = 1'b0;
          rejectedNext   = 1'b0;
          readFlagNext   = 1'b0;
          if (delayZero) begin
            stateNext  = SFastWin;
            cmd.lenSel = LenFastWin;
          end else begin
            stateNext  = SDelay;
            cmd.lenSel = LenDelay;
          end
        end
      end
      SDelay: begin
        if (phaseDone) begin
          stateNext     = SFastWin;
          cmd.loadPhase = 1'b1;
          cmd.lenSel    = LenFastWin;
        end
      end
      SFastWin: begin
        if (phaseDone) begin
          cmd.loadPhase = 1'b1;
          if (fastTrig) begin
            stateNext  = SShape;
            cmd.lenSel = LenShape;
          end else begin
            stateNext  = SRecover;
            cmd.lenSel = LenRecover;
          end
        end
      end
      SShape: begin
        if (rejNow) begin
          stateNext     = SRecover;
          cmd.loadPhase = 1'b1;
          cmd.lenSel    = LenRecover;
        end else if (phaseDone) begin
          stateNext     = SConvert;
          cmd.loadPhase = 1'b1;
          cmd.lenSel    = LenConvert;
          cmd.startConv = 1'b1;
        end
      end
      SConvert: begin
        if (phaseDone) begin
          if (valDecided || decideNow || rejected || rejNow) begin
            stateNext     = SRecover;
            cmd.loadPhase = 1'b1;
            cmd.lenSel    = LenRecover;
            readFlagNext  = valDecided ? valOk : passNow;
          end else begin
            stateNext = SAwaitVal;
          end
        end
      end
      SAwaitVal: begin
        if (rejNow || decideNow) begin
          stateNext     = SRecover;
          cmd.loadPhase = 1'b1;
          cmd.lenSel    = LenRecover;
          readFlagNext  = passNow;
        end
      end
      SRecover: begin
        if (phaseDone) begin
          stateNext    = SIdle;
          readFlagNext = 1'b0;
        end
      end
      default: begin
        stateNext    = SIdle;
        readFlagNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SIdle;
      valDecided <= 1'b0;
      valOk      <= 1'b0;
      rejected   <= 1'b0;
      readFlag   <= 1'b0;
    end else begin
      state      <= stateNext;
      valDecided <= valDecidedNext;
      valOk      <= valOkNext;
      rejected   <= rejectedNext;
      readFlag   <= readFlagNext;
    end
  end

  assign busy         = state != SIdle;
  assign fastWinOpen  = state == SFastWin;
  assign convertStart = (state == SConvert) && convFirst;
  assign readoutReq   = readFlag;

endmodule

// File: rtl/chanTrigSeq.sv
module chanTrigSeq
  import trigSeqPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfdHit,
  input  logic             fastTrig,
  input  logic             validate,
  input  logic             eventReject,
  input  logic [CNT_W-1:0] cfgDelay,
  input  logic [CNT_W-1:0] cfgFastWin,
  input  logic [CNT_W-1:0] cfgShape,
  input  logic [CNT_W-1:0] cfgConvert,
  input  logic [CNT_W-1:0] cfgValDelay,
  input  logic [CNT_W-1:0] cfgValWidth,
  input  logic             cfgValFromHit,
  input  logic [CNT_W-1:0] cfgRecover,
  output logic             busy,
  output logic             fastWinOpen,
  output logic             valWinOpen,
  output logic             convertStart,
  output logic             readoutReq
);

  tmrCmd_t cmd;
  logic phaseDone, delayZero, convFirst, valRefReached, valLast;

  trigSeqTimers #(.CNT_W(CNT_W)) u_timers (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .cfgDelay     (cfgDelay),
    .cfgFastWin   (cfgFastWin),
    .cfgShape     (cfgShape),
    .cfgConvert   (cfgConvert),
    .cfgValDelay  (cfgValDelay),
    .cfgValWidth  (cfgValWidth),
    .cfgValFromHit(cfgValFromHit),
    .cfgRecover   (cfgRecover),
    .phaseDone    (phaseDone),
    .delayZero    (delayZero),
    .convFirst    (convFirst),
    .valRefReached(valRefReached),
    .valLast      (valLast)
  );

  trigSeqCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfdHit       (cfdHit),
    .fastTrig     (fastTrig),
    .validate     (validate),
    .eventReject  (eventReject),
    .phaseDone    (phaseDone),
    .delayZero    (delayZero),
    .convFirst    (convFirst),
    .valRefReached(valRefReached),
    .valLast      (valLast),
    .cmd          (cmd),
    .busy         (busy),
    .fastWinOpen  (fastWinOpen),
    .valWinOpen   (valWinOpen),
    .convertStart (convertStart),
    .readoutReq   (readoutReq)
  );

endmodule

// File: rtl/chanTrigSeqChk.sv
module chanTrigSeqChk (
  input logic clk,
  input logic rstN,
  input logic cfdHit,
  input logic busy,
  input logic fastWinOpen,
  input logic valWinOpen,
  input logic convertStart,
  input logic readoutReq
);

  // R4
  convert_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convertStart |=> !convertStart);

  // R4
  convert_engaged_chk: assert property (@(posedge clk) disable iff (!rstN)
    convertStart |-> (busy && !fastWinOpen));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cfdHit));

  // R2
  window_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fastWinOpen && valWinOpen));

  // R6
  readout_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    readoutReq |-> (busy && !valWinOpen && !convertStart && !fastWinOpen));

  // R6
  readout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readoutReq) |-> !busy);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(fastWinOpen || valWinOpen || convertStart || readoutReq));

endmodule

bind chanTrigSeq chanTrigSeqChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfdHit      (cfdHit),
  .busy        (busy),
  .fastWinOpen (fastWinOpen),
  .valWinOpen  (valWinOpen),
  .convertStart(convertStart),
  .readoutReq  (readoutReq)
);

// File: tb/chanTrigSeq_bench.sv
`timescale 1ns/1ps
module chanTrigSeq_bench;

  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfdHit = 1'b0, fastTrig = 1'b0, validate = 1'b0, eventReject = 1'b0;
  logic [CNT_W-1:0] cfgDelay = '0, cfgFastWin = '0, cfgShape = '0, cfgConvert = '0;
  logic [CNT_W-1:0] cfgValDelay = '0, cfgValWidth = '0, cfgRecover = '0;
  logic cfgValFromHit = 1'b0;
  logic busy, fastWinOpen, valWinOpen, convertStart, readoutReq;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  chanTrigSeq #(.CNT_W(CNT_W)) u_chanTrigSeq (
    .clk(clk), .rstN(rstN), .cfdHit(cfdHit), .fastTrig(fastTrig),
    .validate(validate), .eventReject(eventReject),
    .cfgDelay(cfgDelay), .cfgFastWin(cfgFastWin), .cfgShape(cfgShape),
    .cfgConvert(cfgConvert), .cfgValDelay(cfgValDelay), .cfgValWidth(cfgValWidth),
    .cfgValFromHit(cfgValFromHit), .cfgRecover(cfgRecover),
    .busy(busy), .fastWinOpen(fastWinOpen), .valWinOpen(valWinOpen),
    .convertStart(convertStart), .readoutReq(readoutReq)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int clampLen(input int len);
    return (len < 1) ? 1 : len;
  endfunction

  task automatic chk(input string tag, input string what, input int cyc,
                     input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: got %b expected %b", tag, what, cyc, got, exp);
    end
  endtask

  // One event from the hit on; expected outputs per cycle follow R2..R11, R13.
  // Cycle c is the c-th cycle after the clock edge that samples the hit.
  task automatic runEvent(input string tag, input int d, input int w, input int s,
                          input int cv, input int vd, input int vw, input bit md,
                          input int r, input bit fl, input bit vl, input int rc,
                          input int hitAgain);
    int we, se, ce, vwe, re, fwEnd, recS, t0, cEnd, o, e, vEnd, endC;
    bit conv, rd;
    we = clampLen(w); se = clampLen(s); ce = clampLen(cv);
    vwe = clampLen(vw); re = clampLen(r);
    cfgDelay = CNT_W'(d); cfgFastWin = CNT_W'(w); cfgShape = CNT_W'(s);
    cfgConvert = CNT_W'(cv); cfgValDelay = CNT_W'(vd); cfgValWidth = CNT_W'(vw);
    cfgValFromHit = md; cfgRecover = CNT_W'(r);
    fwEnd = d + we; conv = 1'b0; rd = 1'b0; t0 = -100; o = 1; vEnd = 0;
    if (!fl) begin
      recS = fwEnd + 1;                                // R3
    end else if (rc > fwEnd && rc <= fwEnd + se) begin
      recS = rc + 1;                                   // R8
    end else begin
      conv = 1'b1;
      t0   = fwEnd + se + 1;                           // R4
      cEnd = t0 + ce - 1;
      o    = md ? imax(vd, t0) : t0 + vd;              // R5
      e    = o + vwe - 1;
      if (rc >= t0 && rc <= e) begin                   // R9, R10 tie
        recS = imax(cEnd, rc) + 1;
        vEnd = rc;
      end else begin                                   // R7
        recS = imax(cEnd, e) + 1;
        vEnd = e;
        rd   = vl;                                     // R6
      end
    end
    endC = recS + re - 1;                              // R11
    cfdHit = 1'b1; fastTrig = fl; validate = vl; eventReject = 1'b0;
    for (int c = 1; c <= endC + 1; c++) begin
      @(negedge clk);
      chk(tag, "busy", c, busy, c <= endC);
      chk(tag, "fastWinOpen", c, fastWinOpen, c > d && c <= fwEnd);
      chk(tag, "convertStart", c, convertStart, conv && c == t0);
      chk(tag, "valWinOpen", c, valWinOpen, conv && c >= o && c <= vEnd);
      chk(tag, "readoutReq", c, readoutReq, rd && c >= recS && c <= endC);
      cfdHit = (c == hitAgain) && (c <= endC);
      eventReject = (c == rc);
    end
    cfdHit = 1'b0; eventReject = 1'b0; fastTrig = 1'b0; validate = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R11 watchdog: got running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seedSet;
    seedSet = $urandom(32'd7331);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state, checked while still in reset and after release
    chk("R1", "busy", 0, busy, 1'b0);
    chk("R1", "readoutReq", 0, readoutReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy", 0, busy, 1'b0);
    chk("R1", "fastWinOpen", 0, fastWinOpen, 1'b0);
    chk("R1", "valWinOpen", 0, valWinOpen, 1'b0);
    chk("R1", "convertStart", 0, convertStart, 1'b0);
    chk("R1", "readoutReq", 0, readoutReq, 1'b0);

    // R12: broadcast inputs while idle
    fastTrig = 1'b1; validate = 1'b1; eventReject = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R12", "busy", i, busy, 1'b0);
      chk("R12", "any output", i,
          fastWinOpen | valWinOpen | convertStart | readoutReq, 1'b0);
    end
    fastTrig = 1'b0; validate = 1'b0; eventReject = 1'b0;
    @(negedge clk);

    // directed corner cases
    runEvent("R2", 0, 3, 4, 6, 2, 3, 1'b0, 3, 1'b1, 1'b1, -1, 0);   // zero delay, readout
    runEvent("R3", 4, 2, 5, 5, 1, 2, 1'b0, 4, 1'b0, 1'b1, -1, 0);   // no fast trigger
    runEvent("R8", 2, 2, 6, 5, 1, 2, 1'b0, 3, 1'b1, 1'b1, 6, 0);    // reject in shaping
    runEvent("R9", 1, 2, 3, 8, 4, 2, 1'b0, 2, 1'b1, 1'b1, 8, 0);    // reject in conversion
    runEvent("R7", 1, 2, 2, 3, 5, 4, 1'b0, 2, 1'b1, 1'b1, -1, 0);   // window past conversion
    runEvent("R5", 3, 2, 2, 6, 1, 3, 1'b1, 2, 1'b1, 1'b1, -1, 0);   // from-hit offset clamps
    runEvent("R5", 0, 1, 1, 9, 7, 2, 1'b1, 2, 1'b1, 1'b0, -1, 0);   // from-hit offset inside conv
    runEvent("R10", 2, 2, 3, 10, 1, 2, 1'b0, 3, 1'b1, 1'b1, 12, 0); // reject after decision
    runEvent("R10", 2, 2, 3, 10, 1, 2, 1'b0, 3, 1'b1, 1'b1, 10, 0); // reject on decision cycle
    runEvent("R6", 1, 1, 2, 4, 0, 1, 1'b0, 5, 1'b1, 1'b0, -1, 0);   // validation absent
    runEvent("R11", 1, 2, 2, 3, 0, 2, 1'b0, 3, 1'b1, 1'b1, -1, 3);  // hit while busy
    runEvent("R11", 0, 1, 1, 1, 0, 1, 1'b0, 1, 1'b1, 1'b1, -1, 2);  // back to back
    runEvent("R13", 0, 0, 0, 0, 0, 0, 1'b0, 0, 1'b1, 1'b1, -1, 0);  // zero lengths

    // constrained random events
    for (int n = 0; n < 160; n++) begin
      int d, w, s, cv, vd, vw, r, rc, span;
      bit md, fl, vl;
      d  = int'($urandom_range(0, 20));
      w  = int'($urandom_range(1, 8));
      s  = int'($urandom_range(1, 15));
      cv = int'($urandom_range(1, 20));
      vd = int'($urandom_range(0, 30));
      vw = int'($urandom_range(1, 10));
      r  = int'($urandom_range(1, 10));
      md = 1'($urandom_range(0, 1));
      fl = ($urandom_range(0, 3) != 0);
      vl = 1'($urandom_range(0, 1));
      span = d + w + s + cv + vd + vw + 5;
      rc = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(1, span));
      runEvent("R6", d, w, s, cv, vd, vw, md, r, fl, vl, rc,
               int'($urandom_range(1, 25)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule